// File: doc/BRIEF.md
# Indexed Color Palette Port

This block lets a processor reach a color palette memory through a narrow byte window. Two palettes, one for background and one for objects, each present two byte registers to the processor: a pointer register and a data register. The pointer selects one byte of the palette's 64-byte space and carries a flag that makes the pointer step forward after every data write. Color words are 16 bits with the top bit always reading as zero. Both palettes live in one shared 64-word store: background colors use words 0 to 31 and object colors use words 32 to 63.

The data register's read value is not looked up on demand. A byte latch per palette is loaded whenever the pointer is written and again after every data write. This lets a read return at once with no lookup delay.

Top module: `pal_port`

## Requirements
- R1: A pointer write (`reg_sel`=0) stores `wr_data[5:0]` as the byte pointer and `wr_data[7]` as the step flag; `wr_data[6]` is discarded.
- R2: A pointer read returns {step flag, 1, pointer[5:0]}, so bit 6 always reads as 1.
- R3: After a pointer write, a data read (`reg_sel`=1) returns byte pointer[0] of color word pointer>>1 in that palette. Pointer bit 0 = 0 selects bits 7:0 and pointer bit 0 = 1 selects bits 15:8.
- R4: A data write stores `wr_data` into the byte the pointer addresses, and it can be read back through the data register.
- R5: The object palette (`pal_sel`=1) maps to store words 32 to 63 and the background palette (`pal_sel`=0) maps to words 0 to 31. An access to one palette leaves the other palette's pointer, latch and colors unchanged.
- R6: When the step flag is set, a data write advances the pointer by one, wrapping from 63 to 0. The data read value then shows the byte at the new pointer.
- R7: When the step flag is clear, a data write leaves the pointer unchanged, and the data read value becomes the byte just written.
- R8: Bit 15 of every color word is not stored. A high-byte write drops bit 7, and a high-byte read returns bit 7 as 0.
- R9: After reset both pointers, both step flags, both read latches and the whole store are zero. A pointer read therefore returns 0x40 and a data read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | 0 = pointer register, 1 = data register |
| pal_sel | input | 1 | 0 = background palette, 1 = object palette |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read value of the selected register (combinational) |

## Verification
A wrong pointer shows at the port in the very next cycle, because pointer reads are combinational. A latch that is not refreshed, or that is loaded from the wrong word or byte half, shows on the first data read after the write that should have updated it. A wrong word offset between the palettes shows only when the other palette's data is read. For that reason the tests interleave the two palettes and re-point the pointer to already-written bytes, including across the 63-to-0 wrap.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int PTR_W  = 6;
    localparam int BYTE_W = 8;

    typedef enum logic {
        REG_PTR  = 1'b0,
        REG_DATA = 1'b1
    } pal_reg_e;

    // pick a byte half of a color word; bit 15 is never stored
    function automatic logic [BYTE_W-1:0] word_half(input logic [2*BYTE_W-2:0] w,
                                                    input logic hi);
        logic [2*BYTE_W-1:0] full;
        full = {1'b0, w};
        return hi ? full[2*BYTE_W-1:BYTE_W] : full[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/pal_store.sv
module pal_store #(
    parameter int WORD_AW = 6,
    parameter int BYTE_W  = 8,
    parameter int N_RD    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [WORD_AW:0]            wbyte_addr,
    input  logic [BYTE_W-1:0]           wdata,
    input  logic [N_RD*(WORD_AW+1)-1:0] rbyte_addr,
    output logic [N_RD*BYTE_W-1:0]      rbyte
);
    localparam int WORDS = 1 << WORD_AW;
    localparam int CW    = 2*BYTE_W - 1;

    logic [CW-1:0] mem_d [WORDS];
    logic [CW-1:0] mem_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) mem_d[i] = mem_q[i];
        if (we) begin
            if (wbyte_addr[0])
                mem_d[wbyte_addr[WORD_AW:1]][CW-1:BYTE_W] = wdata[BYTE_W-2:0];
            else
                mem_d[wbyte_addr[WORD_AW:1]][BYTE_W-1:0] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        logic [WORD_AW:0] a;
        assign a = rbyte_addr[r*(WORD_AW+1) +: WORD_AW+1];
        assign rbyte[r*BYTE_W +: BYTE_W] = pal_pkg::word_half(mem_q[a[WORD_AW:1]], a[0]);
    end
endmodule

// File: rtl/pal_ptr_unit.sv
module pal_ptr_unit #(
    parameter int PTR_W  = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] fetch_byte,
    output logic [PTR_W-1:0]  next_ptr,
    output logic [PTR_W-1:0]  ptr_q,
    output logic              step_q,
    output logic [BYTE_W-1:0] latch_q
);
    typedef struct packed {
        logic              step;
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] latch;
    } unit_t;

    unit_t st_d, st_q;

    // pointer after this cycle, computed apart from the latch path
    always_comb begin
        next_ptr = st_q.ptr;
        if (ptr_wr)                    next_ptr = wr_data[PTR_W-1:0];
        else if (dat_wr && st_q.step)  next_ptr = st_q.ptr + 1'b1;
    end

    always_comb begin
        st_d     = st_q;
        st_d.ptr = next_ptr;
        if (ptr_wr) begin
            st_d.step  = wr_data[BYTE_W-1];
            st_d.latch = fetch_byte;
        end else if (dat_wr) begin
            if (st_q.step)
                st_d.latch = fetch_byte;
            else if (st_q.ptr[0])
                st_d.latch = {1'b0, wr_data[BYTE_W-2:0]};
            else
                st_d.latch = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_q   = st_q.ptr;
    assign step_q  = st_q.step;
    assign latch_q = st_q.latch;
endmodule

// File: rtl/pal_port.sv
module pal_port #(
    parameter int PTR_W  = pal_pkg::PTR_W,
    parameter int BYTE_W = pal_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic              pal_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int N_PAL   = 2;
    localparam int WORD_AW = PTR_W;   // one palette bit + PTR_W-1 word bits
    localparam int BA_W    = WORD_AW + 1;

    logic [N_PAL*PTR_W-1:0]  ptr_flat;
    logic [N_PAL-1:0]        step_flat;
    logic [N_PAL*BYTE_W-1:0] latch_flat;
    logic [N_PAL*BA_W-1:0]   fetch_addr;
    logic [N_PAL*BYTE_W-1:0] fetch_byte;
    logic [BA_W-1:0]         wbyte_addr;
    logic                    store_we;

    for (genvar p = 0; p < N_PAL; p++) begin : g_pal
        logic [PTR_W-1:0] nxt;
        logic             hit;
        assign hit = wr_en && (pal_sel == p[0]);
        pal_ptr_unit #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .ptr_wr    (hit && reg_sel == pal_pkg::REG_PTR),
            .dat_wr    (hit && reg_sel == pal_pkg::REG_DATA),
            .wr_data   (wr_data),
            .fetch_byte(fetch_byte[p*BYTE_W +: BYTE_W]),
            .next_ptr  (nxt),
            .ptr_q     (ptr_flat[p*PTR_W +: PTR_W]),
            .step_q    (step_flat[p]),
            .latch_q   (latch_flat[p*BYTE_W +: BYTE_W])
        );
        assign fetch_addr[p*BA_W +: BA_W] = {p[0], nxt};
    end

    assign store_we   = wr_en && reg_sel == pal_pkg::REG_DATA;
    assign wbyte_addr = {pal_sel, ptr_flat[pal_sel*PTR_W +: PTR_W]};

    pal_store #(.WORD_AW(WORD_AW), .BYTE_W(BYTE_W), .N_RD(N_PAL)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (store_we),
        .wbyte_addr(wbyte_addr),
        .wdata     (wr_data),
        .rbyte_addr(fetch_addr),
        .rbyte     (fetch_byte)
    );

    always_comb begin
        if (reg_sel == pal_pkg::REG_PTR) begin
            rd_data = '0;
            rd_data[PTR_W-1:0] = ptr_flat[pal_sel*PTR_W +: PTR_W];
            rd_data[BYTE_W-2]  = 1'b1;
            rd_data[BYTE_W-1]  = step_flat[pal_sel];
        end else begin
            rd_data = latch_flat[pal_sel*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk #(
    parameter int PTR_W  = 6,
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    reg_sel,
    input logic                    pal_sel,
    input logic [BYTE_W-1:0]       wr_data,
    input logic [BYTE_W-1:0]       rd_data,
    input logic [2*PTR_W-1:0]      ptr_flat,
    input logic [1:0]              step_flat,
    input logic [2*BYTE_W-1:0]     latch_flat
);
    assert_ptr_bit6_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> rd_data[BYTE_W-2]);

    for (genvar p = 0; p < 2; p++) begin : g_p
        assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !reg_sel && pal_sel == p[0]) |=>
            (ptr_flat[p*PTR_W +: PTR_W] == $past(wr_data[PTR_W-1:0]) &&
             step_flat[p] == $past(wr_data[BYTE_W-1])));

        assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && reg_sel && pal_sel == p[0] && step_flat[p]) |=>
            ptr_flat[p*PTR_W +: PTR_W] == $past(ptr_flat[p*PTR_W +: PTR_W]) + 1'b1);

        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && reg_sel && pal_sel == p[0] && !step_flat[p]) |=>
            $stable(ptr_flat[p*PTR_W +: PTR_W]));

        assert_other_pal_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && pal_sel != p[0]) |=>
            ($stable(ptr_flat[p*PTR_W +: PTR_W]) && $stable(latch_flat[p*BYTE_W +: BYTE_W])));

        assert_hi_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ptr_flat[p*PTR_W] |-> !latch_flat[p*BYTE_W + BYTE_W-1]);
    end
endmodule

bind pal_port pal_port_chk #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_sel   (reg_sel),
    .pal_sel   (pal_sel),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .ptr_flat  (ptr_flat),
    .step_flat (step_flat),
    .latch_flat(latch_flat)
);

// File: tb/pal_port_tb.sv
module pal_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic       pal_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pal_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .pal_sel(pal_sel), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic wr(input logic pal, input logic rs, input logic [7:0] d);
        @(negedge clk);
        pal_sel = pal; reg_sel = rs; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic pal, input logic rs, input logic [7:0] exp,
                          input string req);
        pal_sel = pal; reg_sel = rs;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s pal=%0d reg=%0d actual=%02h expected=%02h",
                     req, pal, rs, rd_data, exp);
        end
    endtask

    task automatic t_reset;
        rd_chk(0, 0, 8'h40, "R9");
        rd_chk(1, 0, 8'h40, "R9");
        rd_chk(0, 1, 8'h00, "R9");
        rd_chk(1, 1, 8'h00, "R9");
    endtask

    task automatic t_pointer;
        wr(0, 0, 8'hBF); rd_chk(0, 0, 8'hFF, "R2");
        wr(0, 0, 8'h05); rd_chk(0, 0, 8'h45, "R1");
        wr(0, 0, 8'h40); rd_chk(0, 0, 8'h40, "R1");
    endtask

    task automatic t_step_fill;
        wr(0, 0, 8'h80);
        wr(0, 1, 8'h11); wr(0, 1, 8'h22); wr(0, 1, 8'h33); wr(0, 1, 8'h44);
        rd_chk(0, 0, 8'hC4, "R6");
        wr(0, 0, 8'h00); rd_chk(0, 1, 8'h11, "R3");
        wr(0, 0, 8'h01); rd_chk(0, 1, 8'h22, "R3");
        wr(0, 0, 8'h03); rd_chk(0, 1, 8'h44, "R4");
    endtask

    task automatic t_top_bit;
        wr(0, 0, 8'h01);
        wr(0, 1, 8'hFF);
        rd_chk(0, 1, 8'h7F, "R7");
        rd_chk(0, 0, 8'h41, "R7");
        wr(0, 0, 8'h01); rd_chk(0, 1, 8'h7F, "R8");
    endtask

    task automatic t_objects;
        wr(1, 0, 8'h00); rd_chk(1, 1, 8'h00, "R5");
        wr(1, 0, 8'h80); wr(1, 1, 8'h5A);
        rd_chk(1, 0, 8'hC1, "R5");
        rd_chk(0, 0, 8'h41, "R5");
        wr(0, 0, 8'h00); rd_chk(0, 1, 8'h11, "R5");
        wr(1, 0, 8'h00); rd_chk(1, 1, 8'h5A, "R5");
    endtask

    task automatic t_wrap;
        wr(0, 0, 8'hBF);
        wr(0, 1, 8'hAB);
        rd_chk(0, 0, 8'hC0, "R6");
        rd_chk(0, 1, 8'h11, "R6");
        wr(0, 0, 8'h3F); rd_chk(0, 1, 8'h2B, "R8");
        wr(0, 0, 8'h80); wr(0, 1, 8'h99);
        rd_chk(0, 1, 8'h7F, "R6");
        wr(0, 0, 8'h00); rd_chk(0, 1, 8'h99, "R4");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_step_fill();
        t_top_bit();
        t_objects();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule